// File: doc/BRIEF.md
# Two-Level Carry-Lookahead Adder/Subtractor

This block adds or subtracts two two's-complement words in a single combinational pass. The operand is cut into equal slices. Each slice forms per-bit generate (both bits set) and propagate (bits differ) terms. It turns them into flat two-level carries for its own bits, its sum bits and one slice-wide generate/propagate pair. A second lookahead stage applies the same flat equations to the slice pairs and the incoming carry. That stage yields the carry into every slice and the final carry-out, so no carry ever walks from bit to bit across the word.

A mode input selects subtraction. In that mode the second operand is inverted and the carry-in is forced to one, so the block returns the difference. An external carry-in is honoured for addition only. The outputs are the result word, the carry-out and a signed overflow flag. Overflow is raised when the carry entering the top bit disagrees with the carry leaving it.

Top module: `cla_addsub`

## Requirements
- R1: With `sub` = 0, {`cout`, `sum`} equals `a` + `b` + `cin_ext` as an unsigned sum one bit wider than the operands.
- R2: With `sub` = 1, `sum` equals (`a` - `b`) modulo 2^WIDTH and `cout` is 1 exactly when `a` >= `b` read as unsigned numbers (no borrow).
- R3: `ovf` is 1 exactly when the signed interpretation of the true result (a+b+cin_ext for addition, a-b for subtraction, bit WIDTH-1 taken as the sign) lies outside [-2^(WIDTH-1), 2^(WIDTH-1)-1].
- R4: During subtraction `cin_ext` has no effect: `sum`, `cout` and `ovf` are the same for `cin_ext` = 0 and 1.
- R5: A carry launched at bit 0 reaches the top of the word: all-ones plus one gives `sum` = 0, `cout` = 1, `ovf` = 0.
- R6: The most negative value minus one (0x8000 - 0x0001 at the default width) gives 0x7FFF with `ovf` = 1 and `cout` = 1.
- R7: Carries cross slice boundaries: 0x0FFF + 0x0001 gives 0x1000, 0x00FF + 0x0001 gives 0x0100, and 0x7FFF + 0x0001 gives 0x8000 with `ovf` = 1 and `cout` = 0.
- R8: All-zero inputs in addition mode give `sum` = 0, `cout` = 0, `ovf` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | WIDTH | First operand |
| b | input | WIDTH | Second operand (the subtrahend in subtract mode) |
| sub | input | 1 | 1 selects a - b, 0 selects a + b + cin_ext |
| cin_ext | input | 1 | Carry-in used in addition mode only |
| sum | output | WIDTH | Result word |
| cout | output | 1 | Carry out of the top bit (1 = no borrow when subtracting) |
| ovf | output | 1 | Signed overflow of the result |

## Verification
An 8-bit, two-slice copy is swept over every operand pair, both modes and both carry-in values. Every carry pattern across the slice boundary is therefore exercised, and so is the rule that the external carry-in is ignored during subtraction. A slice carry taken from the wrong group pair, or a second-level term with a missing product, would corrupt sums only for specific carry chains, and those chains are the ones the sweep reaches. The 16-bit instance is driven with the chain-length corners: all-ones plus one, a carry stopping just below each slice edge, and the signed boundaries. A sign-bit carry taken from the wrong position, or a subtract path that misses the +1, shows up there as a wrong overflow flag or an off-by-one difference.

// File: rtl/cla_pkg.sv
package cla_pkg;

    parameter int unsigned CLA_WIDTH_DEF = 16;
    parameter int unsigned CLA_SLICE_DEF = 4;

    typedef struct packed {
        logic cout;
        logic ovf;
    } cla_flags_t;

endpackage

// File: rtl/cla_lookahead.sv
// Flat lookahead over N propagate/generate pairs.
// carry_d[k] is the carry entering position k (carry_d[0] is cin).
// grp_p_d / grp_g_d summarise all N positions.
module cla_lookahead #(
    parameter int unsigned N = 4
) (
    input  logic [N-1:0] prop,
    input  logic [N-1:0] gen,
    input  logic         cin,
    output logic [N-1:0] carry_d,
    output logic         grp_p_d,
    output logic         grp_g_d
);

    logic term;

    always_comb begin
        carry_d = '0;
        carry_d[0] = cin;
        // carry into position k+1: every product is an AND of inputs only
        for (int k = 0; k < N - 1; k++) begin
            term = cin;
            for (int i = 0; i <= k; i++) term = term & prop[i];
            carry_d[k+1] = term;
            for (int j = 0; j <= k; j++) begin
                term = gen[j];
                for (int i = j + 1; i <= k; i++) term = term & prop[i];
                carry_d[k+1] = carry_d[k+1] | term;
            end
        end
        grp_p_d = &prop;
        grp_g_d = 1'b0;
        for (int j = 0; j < N; j++) begin
            term = gen[j];
            for (int i = j + 1; i < N; i++) term = term & prop[i];
            grp_g_d = grp_g_d | term;
        end
    end

endmodule

// File: rtl/cla_slice.sv
// One lookahead slice: bit-level P/G, flat internal carries, sums,
// and a slice-wide P/G pair for the second level.
module cla_slice #(
    parameter int unsigned SW = 4
) (
    input  logic [SW-1:0] opa,
    input  logic [SW-1:0] opb,
    input  logic          cin,
    output logic [SW-1:0] sum_d,
    output logic          sp_d,
    output logic          sg_d
);

    logic [SW-1:0] bit_p_d;
    logic [SW-1:0] bit_g_d;
    logic [SW-1:0] bit_c_d;

    assign bit_p_d = opa ^ opb;
    assign bit_g_d = opa & opb;

    cla_lookahead #(.N(SW)) u_look (
        .prop    (bit_p_d),
        .gen     (bit_g_d),
        .cin     (cin),
        .carry_d (bit_c_d),
        .grp_p_d (sp_d),
        .grp_g_d (sg_d)
    );

    assign sum_d = bit_p_d ^ bit_c_d;

endmodule

// File: rtl/cla_addsub.sv
module cla_addsub
    import cla_pkg::*;
#(
    parameter int unsigned WIDTH = CLA_WIDTH_DEF,
    parameter int unsigned SLICE = CLA_SLICE_DEF
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             sub,
    input  logic             cin_ext,
    output logic [WIDTH-1:0] sum,
    output logic             cout,
    output logic             ovf
);

    localparam int unsigned NSLICE = WIDTH / SLICE;
    localparam int unsigned MSB    = WIDTH - 1;

    logic [WIDTH-1:0]  b_eff_d;
    logic              c0_d;
    logic [NSLICE-1:0] sl_p_d;
    logic [NSLICE-1:0] sl_g_d;
    logic [NSLICE-1:0] sl_c_d;
    logic              top_p_d;
    logic              top_g_d;
    logic [WIDTH-1:0]  sum_d;
    cla_flags_t        flags_d;

    // subtract: invert b and force the incoming carry high
    assign b_eff_d = b ^ {WIDTH{sub}};
    assign c0_d    = sub | cin_ext;

    for (genvar s = 0; s < NSLICE; s++) begin : g_slice
        cla_slice #(.SW(SLICE)) u_slice (
            .opa   (a[s*SLICE +: SLICE]),
            .opb   (b_eff_d[s*SLICE +: SLICE]),
            .cin   (sl_c_d[s]),
            .sum_d (sum_d[s*SLICE +: SLICE]),
            .sp_d  (sl_p_d[s]),
            .sg_d  (sl_g_d[s])
        );
    end

    // second-level unit: carries into every slice from slice P/G and c0
    cla_lookahead #(.N(NSLICE)) u_level2 (
        .prop    (sl_p_d),
        .gen     (sl_g_d),
        .cin     (c0_d),
        .carry_d (sl_c_d),
        .grp_p_d (top_p_d),
        .grp_g_d (top_g_d)
    );

    always_comb begin
        flags_d.cout = top_g_d | (top_p_d & c0_d);
        // carry into the sign bit recovered as p ^ s at that position
        flags_d.ovf  = flags_d.cout ^ (a[MSB] ^ b_eff_d[MSB] ^ sum_d[MSB]);
    end

    assign sum  = sum_d;
    assign cout = flags_d.cout;
    assign ovf  = flags_d.ovf;

endmodule

// File: rtl/cla_addsub_chk.sv
module cla_addsub_chk #(
    parameter int unsigned WIDTH = 16
) (
    input logic [WIDTH-1:0] a,
    input logic [WIDTH-1:0] b,
    input logic             sub,
    input logic             cin_ext,
    input logic [WIDTH-1:0] sum,
    input logic             cout,
    input logic             ovf
);

    logic [WIDTH:0]   ref_add;
    logic [WIDTH:0]   ref_sub;
    logic [WIDTH-1:0] nb;

    always_comb begin
        nb      = ~b;
        ref_add = {1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin_ext};
        ref_sub = {1'b0, a} + {1'b0, nb} + {{WIDTH{1'b0}}, 1'b1};
        if (!$isunknown({a, b, sub, cin_ext})) begin
            // R1
            a_r1_add_result: assert (sub || ({cout, sum} == ref_add))
                else $error("add result mismatch");
            // R2 and R4
            a_r2_sub_result: assert (!sub || ({cout, sum} == ref_sub))
                else $error("sub result mismatch");
            // R3
            a_r3_ovf: assert (ovf == (sub ? ((a[WIDTH-1] != b[WIDTH-1]) && (sum[WIDTH-1] != a[WIDTH-1]))
                                          : ((a[WIDTH-1] == b[WIDTH-1]) && (sum[WIDTH-1] != a[WIDTH-1]))))
                else $error("overflow flag mismatch");
            // R5
            a_r5_full_chain: assert (!(!sub && !cin_ext && (&a) && (b == {{(WIDTH-1){1'b0}}, 1'b1}))
                                     || (sum == '0 && cout && !ovf))
                else $error("full carry chain mismatch");
        end
    end

endmodule

bind cla_addsub cla_addsub_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/cla_addsub_tb.sv
module cla_addsub_tb;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    // default 16-bit instance
    logic [15:0] a, b, sum;
    logic        sub, cin_ext, cout, ovf;

    cla_addsub u_dut (
        .a(a), .b(b), .sub(sub), .cin_ext(cin_ext),
        .sum(sum), .cout(cout), .ovf(ovf)
    );

    // small configuration for the exhaustive sweep: 8 bits, two slices
    logic [7:0] sa, sb, ssum;
    logic       ssub, scin, scout, sovf;

    cla_addsub #(.WIDTH(8), .SLICE(4)) u_small (
        .a(sa), .b(sb), .sub(ssub), .cin_ext(scin),
        .sum(ssum), .cout(scout), .ovf(sovf)
    );

    task automatic check(input string req, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic void model(input int w, input longint ua, input longint ub,
                                  input bit s, input bit ci,
                                  output longint es, output bit ec, output bit eo);
        longint md, t, xa, xb, r;
        md = longint'(1) << w;
        t  = s ? (ua + (md - 1 - ub) + 1) : (ua + ub + ci);
        es = t % md;
        ec = (t >= md);
        xa = (ua >= md / 2) ? ua - md : ua;
        xb = (ub >= md / 2) ? ub - md : ub;
        r  = s ? (xa - xb) : (xa + xb + ci);
        eo = (r >= md / 2) || (r < -(md / 2));
    endfunction

    task automatic run16(input string req, input logic [15:0] va, input logic [15:0] vb,
                         input bit s, input bit ci);
        longint es; bit ec, eo;
        a = va; b = vb; sub = s; cin_ext = ci;
        #1;
        model(16, longint'(va), longint'(vb), s, ci, es, ec, eo);
        check(req, longint'(sum), es);
        check(req, longint'(cout), longint'(ec));
        check(req, longint'(ovf), longint'(eo));
    endtask

    initial begin
        a = '0; b = '0; sub = 1'b0; cin_ext = 1'b0;
        sa = '0; sb = '0; ssub = 1'b0; scin = 1'b0;
        #3;
        // R8: zero inputs
        check("R8", longint'(sum), 0);
        check("R8", longint'(cout), 0);
        check("R8", longint'(ovf), 0);

        // exhaustive sweep of the 8-bit copy: R1 R2 R3 R4
        for (int ia = 0; ia < 256; ia++) begin
            for (int ib = 0; ib < 256; ib++) begin
                for (int m = 0; m < 4; m++) begin
                    longint es; bit ec, eo;
                    string rq;
                    sa = ia[7:0]; sb = ib[7:0]; ssub = m[1]; scin = m[0];
                    #1;
                    model(8, longint'(ia), longint'(ib), m[1], m[0], es, ec, eo);
                    rq = m[1] ? (m[0] ? "R4" : "R2") : "R1";
                    check(rq, longint'(ssum), es);
                    check(rq, longint'(scout), longint'(ec));
                    check("R3", longint'(sovf), longint'(eo));
                end
            end
        end

        // 16-bit corners
        run16("R5", 16'hFFFF, 16'h0001, 1'b0, 1'b0);
        check("R5", longint'(sum), 0);
        check("R5", longint'(cout), 1);
        run16("R5", 16'hFFFF, 16'h0000, 1'b0, 1'b1);
        run16("R6", 16'h8000, 16'h0001, 1'b1, 1'b0);
        check("R6", longint'(sum), 16'h7FFF);
        check("R6", longint'(ovf), 1);
        run16("R6", 16'h8000, 16'h0001, 1'b1, 1'b1);
        run16("R7", 16'h0FFF, 16'h0001, 1'b0, 1'b0);
        check("R7", longint'(sum), 16'h1000);
        run16("R7", 16'h00FF, 16'h0001, 1'b0, 1'b0);
        check("R7", longint'(sum), 16'h0100);
        run16("R7", 16'h000F, 16'h0000, 1'b0, 1'b1);
        check("R7", longint'(sum), 16'h0010);
        run16("R7", 16'h7FFF, 16'h0001, 1'b0, 1'b0);
        check("R7", longint'(ovf), 1);
        check("R7", longint'(cout), 0);
        run16("R3", 16'h8000, 16'h8000, 1'b0, 1'b0);
        run16("R2", 16'h0000, 16'h0001, 1'b1, 1'b0);
        run16("R2", 16'h1234, 16'h1234, 1'b1, 1'b0);
        run16("R3", 16'h7FFF, 16'hFFFF, 1'b1, 1'b0);

        // random 16-bit vectors: R1 R2 R4
        for (int n = 0; n < 4000; n++) begin
            logic [15:0] ra, rb;
            logic [1:0]  rm;
            ra = 16'($urandom); rb = 16'($urandom); rm = 2'($urandom);
            run16(rm[1] ? (rm[0] ? "R4" : "R2") : "R1", ra, rb, rm[1], rm[0]);
        end

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

endmodule